// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a synthesizable target-side model of a byte-wide serial EEPROM on a two-wire bus. It runs on a system clock and samples the bus clock (SCL) and data (SDA) lines through synchronizers. It never drives SDA high. It only asserts a pull-down enable, which the chip's pad turns into an open-drain driver, so the line idles high through the external pull-up.

A controller opens every transaction with a start condition and then sends a device byte. The block answers only to the device byte that carries its fixed type code and the two strap pins. After a write device byte come two word-address bytes and then data bytes, which are stored with the address wrapping inside a 64-byte page. A read device byte makes the block return bytes from its address counter until the controller declines to acknowledge.

A random read is a write of the address only, followed by a repeated start and a read device byte. A read device byte without the address phase continues from wherever the counter stands. A write-protect input keeps the array unchanged while the bus protocol carries on as normal. The word address is 15 bits wide. The default array holds 2048 bytes and is indexed by the low address bits, and setting the array width parameter to 15 gives the full 32768 bytes.

Top module: `eeprom_target`

## Requirements
- R1: While reset is high, and on the first cycle after it, the SDA pull-down enable is low.
- R2: A start (SDA falls while SCL is high) begins a new transaction from any state, including a repeated start in mid-transaction. A stop (SDA rises while SCL is high) returns the block to idle, and bytes clocked after a stop without a new start get no acknowledge.
- R3: A device byte, sent MSB first, is acknowledged by holding SDA low during the ninth SCL pulse only when bits 7..4 are 1010, bit 3 is 0 and bits 2..1 equal the strap pins. Bit 0 is 1 for read and 0 for write. Any other device byte gets no acknowledge, and the block ignores the bus until the next start.
- R4: After a write device byte, two word-address bytes follow, high byte first, and each is acknowledged. Only bits 6..0 of the high byte are used, so bit 7 has no effect on the address.
- R5: A data byte after the word address is acknowledged and stored at the current address.
- R6: Each stored byte advances the low 6 address bits, wrapping within the 64-byte page. The upper address bits stay unchanged.
- R7: A random read (word address, repeated start, read device byte) returns the byte stored at that address, MSB first.
- R8: Each byte sent on a read advances the full 15-bit address counter, crossing page borders. A read ends when the controller answers a byte with SDA high, and a later read device byte with no address phase continues at the next address.
- R9: While write protect is high, data bytes are still acknowledged but the array does not change.
- R10: The pull-down enable changes only after SCL has fallen, never while SCL stays high. Read bits therefore change in the SCL low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| strap | input | 2 | Device address strap pins (device byte bits 2..1) |
| wp | input | 1 | Write protect; 1 blocks all array updates |

## Verification
The assertions assume that both SCL phases last several system clocks longer than the synchronizer latency. They also assume that SDA changes only in the SCL low phase, except for starts and stops. A controller must also never signal a start or stop while the block holds SDA low. The stimulus keeps to these assumptions by holding every bus quarter-phase for ten system clocks and by changing SDA only after SCL has been low for a full quarter-phase. It issues stops only after the block has released the line at the end of an acknowledge or a read byte.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT
    } tstate_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_hit(input logic [7:0] b, input logic [1:0] pins);
        return (b[7:4] == DEV_TYPE) && (b[3] == 1'b0) && (b[2:1] == pins);
    endfunction

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler
    import eeprom_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [SYNC-1:0] scl_sr, sda_sr;
    logic            scl_q, sda_q;
    logic            scl_s, sda_s;

    assign scl_s = scl_sr[SYNC-1];
    assign sda_s = sda_sr[SYNC-1];

    generate
        if (SYNC == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sr <= '1;
                    sda_sr <= '1;
                end else begin
                    scl_sr <= scl_in;
                    sda_sr <= sda_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sr <= '1;
                    sda_sr <= '1;
                end else begin
                    scl_sr <= {scl_sr[SYNC-2:0], scl_in};
                    sda_sr <= {sda_sr[SYNC-2:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/eeprom_proto.sv
module eeprom_proto
    import eeprom_pkg::*;
#(
    parameter int WA = 15,
    parameter int PB = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic [1:0]    strap,
    input  logic          wp,
    input  logic [7:0]    rdata,
    output logic          mem_we,
    output logic [WA-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          pull
);
    localparam logic [WA-1:0] ONE = {{(WA-1){1'b0}}, 1'b1};
    localparam logic [PB-1:0] PONE = {{(PB-1){1'b0}}, 1'b1};

    tstate_e       st;
    logic [3:0]    bcnt;
    logic [7:0]    sh;
    logic          ackph;
    logic [WA-1:0] addr;
    logic          byte_in;

    assign byte_in   = ev.scl_fall && !ackph && (bcnt == 4'd8);
    assign mem_we    = (st == ST_WDAT) && byte_in && !wp;
    assign mem_addr  = addr;
    assign mem_wdata = sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            bcnt  <= '0;
            sh    <= '0;
            ackph <= 1'b0;
            pull  <= 1'b0;
            addr  <= '0;
        end else if (ev.start) begin
            st    <= ST_DEV;
            bcnt  <= '0;
            ackph <= 1'b0;
            pull  <= 1'b0;
        end else if (ev.stop) begin
            st    <= ST_IDLE;
            bcnt  <= '0;
            ackph <= 1'b0;
            pull  <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: ;
                ST_RDAT: begin
                    if (ev.scl_rise) begin
                        if (ackph) begin
                            if (ev.sda) begin
                                st    <= ST_IDLE;
                                ackph <= 1'b0;
                            end
                        end else if (bcnt != 4'd8) begin
                            bcnt <= bcnt + 4'd1;
                        end
                    end
                    if (ev.scl_fall) begin
                        if (ackph) begin
                            ackph <= 1'b0;
                            bcnt  <= '0;
                            sh    <= rdata;
                            pull  <= ~rdata[7];
                            addr  <= addr + ONE;
                        end else if (bcnt == 4'd8) begin
                            pull  <= 1'b0;
                            ackph <= 1'b1;
                        end else if (bcnt != 4'd0) begin
                            sh   <= {sh[6:0], 1'b0};
                            pull <= ~sh[6];
                        end
                    end
                end
                default: begin
                    if (ev.scl_rise && !ackph && (bcnt != 4'd8)) begin
                        sh   <= {sh[6:0], ev.sda};
                        bcnt <= bcnt + 4'd1;
                    end
                    if (ev.scl_fall) begin
                        if (ackph) begin
                            ackph <= 1'b0;
                            pull  <= 1'b0;
                            bcnt  <= '0;
                            unique case (st)
                                ST_DEV: begin
                                    if (sh[0]) begin
                                        st   <= ST_RDAT;
                                        sh   <= rdata;
                                        pull <= ~rdata[7];
                                        addr <= addr + ONE;
                                    end else begin
                                        st <= ST_AHI;
                                    end
                                end
                                ST_AHI:  st <= ST_ALO;
                                ST_ALO:  st <= ST_WDAT;
                                default: ;
                            endcase
                        end else if (bcnt == 4'd8) begin
                            ackph <= 1'b1;
                            unique case (st)
                                ST_DEV: begin
                                    if (dev_hit(sh, strap)) begin
                                        pull <= 1'b1;
                                    end else begin
                                        st    <= ST_IDLE;
                                        ackph <= 1'b0;
                                    end
                                end
                                ST_AHI: begin
                                    pull          <= 1'b1;
                                    addr[WA-1:8]  <= sh[WA-9:0];
                                end
                                ST_ALO: begin
                                    pull       <= 1'b1;
                                    addr[7:0]  <= sh;
                                end
                                default: begin
                                    pull <= 1'b1;
                                    addr <= {addr[WA-1:PB], addr[PB-1:0] + PONE};
                                end
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    // R1: line released on the cycle after reset
    a_r1_released_after_reset: assert property (@(posedge clk)
        rst |=> !pull);

    // R3: an acknowledge that follows the device byte needs a matching byte
    a_r3_ack_only_on_match: assert property (@(posedge clk) disable iff (rst)
        ($rose(pull) && $past(st) == ST_DEV) |-> dev_hit($past(sh), strap));

    // R6: a stored byte never moves the page bits
    a_r6_page_wrap: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> addr[WA-1:PB] == $past(addr[WA-1:PB]));

    // R8: entering a read advances the counter by one
    a_r8_read_step: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RDAT && $past(st) != ST_RDAT) |-> addr == $past(addr) + ONE);

    // R10: pull-down steady while sampled SCL stays high
    a_r10_pull_quiet_scl_high: assert property (@(posedge clk) disable iff (rst)
        (ev.scl && $past(ev.scl) && !ev.start && !ev.stop) |-> $stable(pull));

endmodule

// File: rtl/eeprom_target.sv
module eeprom_target
    import eeprom_pkg::*;
#(
    parameter int WA   = 15,
    parameter int PB   = 6,
    parameter int AW   = 11,
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull,
    input  logic [1:0] strap,
    input  logic       wp
);
    bus_ev_t       ev;
    logic          mem_we;
    logic [WA-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;

    i2c_bus_sampler #(.SYNC(SYNC)) u_samp (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    eeprom_proto #(.WA(WA), .PB(PB)) u_proto (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .strap     (strap),
        .wp        (wp),
        .rdata     (mem_rdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .pull      (sda_pull)
    );

    eeprom_store #(.AW(AW), .DW(8)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr[AW-1:0]),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    // R9: protect input blocks every array write strobe
    a_r9_wp_blocks_write: assert property (@(posedge clk) disable iff (rst)
        wp |-> !mem_we);

endmodule

// File: tb/eeprom_target_test.sv
module eeprom_target_test;

    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic [1:0] strap = 2'b10;
    logic sda_pull;
    logic line;

    int errs = 0;
    int checks = 0;

    logic [7:0] model [int];
    int cur_addr = 0;

    logic [7:0] DEV_W, DEV_R;
    assign DEV_W = {4'b1010, 1'b0, strap, 1'b0};
    assign DEV_R = {4'b1010, 1'b0, strap, 1'b1};

    assign line = sda_m & ~sda_pull;

    always #10 clk = ~clk;

    eeprom_target uut (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_m),
        .sda_in   (line),
        .sda_pull (sda_pull),
        .strap    (strap),
        .wp       (wp)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R10 reference: on every clock, pull steady while SCL held high
    logic scl_prev = 1'b1;
    logic pull_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst && scl_m && scl_prev) begin
            chk("R10 pull moved with SCL high", sda_pull, pull_prev);
        end
        scl_prev  <= scl_m;
        pull_prev <= sda_pull;
    end

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wq(1);
        scl_m = 1'b1; wq(2);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        b = line; wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic do_start();
        scl_m = 1'b0; sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b0; wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic do_stop();
        scl_m = 1'b0; sda_m = 1'b0; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b1; wq(1);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(a);
        acked = !a;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic last);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            bit_in(v);
            b[i] = v;
        end
        bit_out(last);
    endtask

    task automatic write_seq(input logic [7:0] hi, input logic [7:0] lo,
                             input int n, input logic [7:0] d0, input string req);
        logic ak;
        int base;
        base = {hi[6:0], lo};
        do_start();
        send_byte(DEV_W, ak); chk({req, " device ack"}, ak, 1);
        send_byte(hi, ak);    chk({req, " addr hi ack"}, ak, 1);
        send_byte(lo, ak);    chk({req, " addr lo ack"}, ak, 1);
        for (int i = 0; i < n; i++) begin
            int a;
            a = (base & 32'h7FC0) | ((base + i) & 32'h3F);
            send_byte(d0 + 8'(i), ak);
            chk({req, " data ack"}, ak, 1);
            if (!wp) model[a] = d0 + 8'(i);
        end
        do_stop();
        cur_addr = (base & 32'h7FC0) | ((base + n) & 32'h3F);
    endtask

    task automatic read_cur(input int n, input string req);
        logic ak;
        logic [7:0] d;
        do_start();
        send_byte(DEV_R, ak); chk({req, " read device ack"}, ak, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(d, i == n - 1);
            chk({req, " read data"}, d, model[(cur_addr + i) & 32'h7FFF]);
        end
        do_stop();
        cur_addr = (cur_addr + n) & 32'h7FFF;
    endtask

    task automatic read_seq(input logic [7:0] hi, input logic [7:0] lo,
                            input int n, input string req);
        logic ak;
        do_start();
        send_byte(DEV_W, ak); chk({req, " device ack"}, ak, 1);
        send_byte(hi, ak);    chk({req, " addr hi ack"}, ak, 1);
        send_byte(lo, ak);    chk({req, " addr lo ack"}, ak, 1);
        cur_addr = {hi[6:0], lo};
        read_cur(n, req);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic ak;
        repeat (4) @(negedge clk);
        chk("R1 pull during reset", sda_pull, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pull after reset", sda_pull, 0);
        wq(2);

        write_seq(8'h01, 8'h23, 1, 8'h5A, "R5 byte write");
        read_seq(8'h01, 8'h23, 1, "R7 random read");

        // R3: wrong strap bits
        do_start();
        send_byte(8'hA0, ak); chk("R3 mismatched device no ack", ak, 0);
        send_byte(8'h01, ak); chk("R3 ignored after mismatch", ak, 0);
        do_stop();

        write_seq(8'h07, 8'hC0, 2, 8'h30, "R5 second write");
        write_seq(8'h07, 8'hBE, 4, 8'h10, "R6 page wrap write");
        read_seq(8'h07, 8'h80, 2, "R6 wrapped bytes");
        read_seq(8'h07, 8'hBF, 2, "R8 sequential across page");
        read_cur(1, "R8 current address read");

        wp = 1'b1;
        write_seq(8'h01, 8'h23, 1, 8'hEE, "R9 protected write");
        wp = 1'b0;
        read_seq(8'h01, 8'h23, 1, "R9 array unchanged");

        write_seq(8'h81, 8'h23, 1, 8'h77, "R4 high bit ignored");
        read_seq(8'h01, 8'h23, 1, "R4 read back");

        // R2: stop mid-frame, then a byte without start
        do_start();
        send_byte(DEV_W, ak); chk("R2 device ack", ak, 1);
        for (int i = 0; i < 4; i++) bit_out(1'b0);
        do_stop();
        scl_m = 1'b0; wq(1);
        send_byte(DEV_W, ak); chk("R2 no ack without start", ak, 0);
        do_stop();
        read_seq(8'h01, 8'h23, 1, "R2 recovery after stop");

        wq(4);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule